// File: doc/BRIEF.md
# Packed Time-of-Day Counter with Alarms

This block keeps elapsed time as a single 32-bit word split into four mixed-radix fields: seconds, minutes, hours and a day count. A prescaler turns a 32.768 kHz reference, presented as a one-cycle enable on the system clock, into a one-second tick. When the prescaler is bypassed, the counters advance on every reference pulse. That mode gives fast bring-up and test.

A stored alarm word uses the same packed layout. Two alarm events are produced. The time-of-day event fires when hours, minutes and seconds match, whatever the day. The full event also needs the day field to match. Every tick gives a second pulse. Each wrap of the seconds, minutes and hours fields gives its own rollover pulse. Software or a neighbouring block can load the time word and the alarm word at any time through strobes.

Top module: `tod_counter`

## Requirements
- R1: The time word packs seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and the day count in bits 31:17. The alarm word uses the same layout.
- R2: Seconds and minutes wrap from 59 to 0. Hours wrap from 23 to 0. Each wrap carries one into the next field up.
- R3: With `div_en` = 1, the time advances once per 32768 `ref_en` pulses.
- R4: With `div_en` = 0, the time advances on every `ref_en` pulse. In a cycle with `ref_en` = 0 and no load, the time word holds and no event pulse is raised.
- R5: A `time_ld` strobe makes `time_word` equal `time_ld_val` one clock later. It raises no event and takes priority over a tick in the same cycle. It restarts the prescaler phase, so the next tick comes a full 32768 pulses after the load.
- R6: The day count wraps from 32767 to 0. That wrap raises no event beyond the usual second, minute, hour and day pulses.
- R7: The event pulses rise one clock after the edge that samples the causing `ref_en`, in the same cycle as the updated `time_word`, and each lasts one cycle. `evt_sec` marks every advance. `evt_min` marks a seconds wrap, `evt_hour` a minutes wrap and `evt_day` an hours wrap.
- R8: `evt_alarm_tod` pulses with an advance whose new hours, minutes and seconds equal those of the alarm word, whatever the day fields hold.
- R9: `evt_alarm_full` pulses only when the new day field matches as well. It is always accompanied by `evt_alarm_tod`.
- R10: An `alarm_ld` strobe stores `alarm_ld_val` without raising any event. An advance in the same cycle is compared against the alarm value held before that edge.
- R11: After reset, the time word and the alarm word are zero, no event is active and the prescaler phase is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| div_en | input | 1 | 1: divide the reference down to seconds; 0: advance on every reference pulse |
| time_ld | input | 1 | Load strobe for the time word |
| time_ld_val | input | 32 | Packed time value to load |
| alarm_ld | input | 1 | Load strobe for the alarm word |
| alarm_ld_val | input | 32 | Packed alarm value to load |
| time_word | output | 32 | Current packed time |
| evt_sec | output | 1 | Advance pulse |
| evt_min | output | 1 | Seconds rollover pulse |
| evt_hour | output | 1 | Minutes rollover pulse |
| evt_day | output | 1 | Hours (24-hour) rollover pulse |
| evt_alarm_tod | output | 1 | Hours/minutes/seconds alarm match pulse |
| evt_alarm_full | output | 1 | Alarm match pulse including the day |

## Verification
Every result of this block is due exactly one clock after the edge that samples its stimulus. A tick, a time load or an alarm load sampled at one rising edge shows up in `time_word` and the event pulses right after that edge. The prescaled tick is due after the 32768th `ref_en` pulse counted from reset, from a disable or from the last load. The bench drives each stimulus on a falling edge and queues the expected time word and event set at once. A monitor pops one item a short delay after each following rising edge, so every comparison lands in the single cycle in which the result is due.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 15;
  localparam int WORD_W = SEC_W + MIN_W + HOUR_W + DAY_W;

  localparam int SEC_LAST  = 59;
  localparam int MIN_LAST  = 59;
  localparam int HOUR_LAST = 23;

  // Packed order puts day at 31:17, hour 16:12, minute 11:6, second 5:0
  typedef struct packed {
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } tod_t;

  typedef struct packed {
    logic alarm_full;
    logic alarm_tod;
    logic day;
    logic hour;
    logic min;
    logic sec;
  } tod_evt_t;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic div_en,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_COUNT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick = ref_en & (~div_en | (cnt_q == CNT_LAST));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !div_en) begin
      cnt_d = '0;
    end else if (ref_en) begin
      cnt_d = tick ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tod_wrap_inc.sv
module tod_wrap_inc #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic [W-1:0] val,
  input  logic         inc,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  always_comb begin
    wrap = inc & (val >= W'(LAST));
    if (wrap) begin
      nxt = '0;
    end else if (inc) begin
      nxt = val + W'(1);
    end else begin
      nxt = val;
    end
  end
endmodule

// File: rtl/tod_advance.sv
module tod_advance
  import tod_pkg::*;
(
  input  tod_t cur,
  output tod_t nxt,
  output logic wrap_sec,
  output logic wrap_min,
  output logic wrap_hour
);
  tod_wrap_inc #(.W(SEC_W), .LAST(SEC_LAST)) u_sec (
    .val(cur.sec), .inc(1'b1), .nxt(nxt.sec), .wrap(wrap_sec)
  );

  tod_wrap_inc #(.W(MIN_W), .LAST(MIN_LAST)) u_min (
    .val(cur.min), .inc(wrap_sec), .nxt(nxt.min), .wrap(wrap_min)
  );

  tod_wrap_inc #(.W(HOUR_W), .LAST(HOUR_LAST)) u_hour (
    .val(cur.hour), .inc(wrap_min), .nxt(nxt.hour), .wrap(wrap_hour)
  );

  // Day count wraps at its natural width
  always_comb begin
    nxt.day = wrap_hour ? cur.day + DAY_W'(1) : cur.day;
  end
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_pkg::*;
(
  input  tod_t cand,
  input  tod_t alarm,
  output logic hit_tod,
  output logic hit_full
);
  always_comb begin
    hit_tod  = (cand.hour == alarm.hour) && (cand.min == alarm.min) &&
               (cand.sec == alarm.sec);
    hit_full = hit_tod && (cand.day == alarm.day);
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_en,
  input  logic        div_en,
  input  logic        time_ld,
  input  logic [31:0] time_ld_val,
  input  logic        alarm_ld,
  input  logic [31:0] alarm_ld_val,
  output logic [31:0] time_word,
  output logic        evt_sec,
  output logic        evt_min,
  output logic        evt_hour,
  output logic        evt_day,
  output logic        evt_alarm_tod,
  output logic        evt_alarm_full
);
  tod_t     time_q, time_d, time_adv;
  tod_t     alarm_q, alarm_d;
  tod_evt_t evt_q, evt_d;
  logic     tick;
  logic     wrap_sec, wrap_min, wrap_hour;
  logic     hit_tod, hit_full;

  tod_prescaler #(.DIV_COUNT(DIV_COUNT)) u_presc (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .div_en(div_en),
    .restart(time_ld), .tick(tick)
  );

  tod_advance u_adv (
    .cur(time_q), .nxt(time_adv),
    .wrap_sec(wrap_sec), .wrap_min(wrap_min), .wrap_hour(wrap_hour)
  );

  tod_alarm_match u_match (
    .cand(time_adv), .alarm(alarm_q), .hit_tod(hit_tod), .hit_full(hit_full)
  );

  // Next-state: load wins over tick; events only on a tick
  always_comb begin
    time_d = time_q;
    evt_d  = '0;
    if (time_ld) begin
      time_d = tod_t'(time_ld_val);
    end else if (tick) begin
      time_d           = time_adv;
      evt_d.sec        = 1'b1;
      evt_d.min        = wrap_sec;
      evt_d.hour       = wrap_min;
      evt_d.day        = wrap_hour;
      evt_d.alarm_tod  = hit_tod;
      evt_d.alarm_full = hit_full;
    end
  end

  always_comb begin
    alarm_d = alarm_ld ? tod_t'(alarm_ld_val) : alarm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q  <= '0;
      alarm_q <= '0;
      evt_q   <= '0;
    end else begin
      time_q  <= time_d;
      alarm_q <= alarm_d;
      evt_q   <= evt_d;
    end
  end

  assign time_word      = time_q;
  assign evt_sec        = evt_q.sec;
  assign evt_min        = evt_q.min;
  assign evt_hour       = evt_q.hour;
  assign evt_day        = evt_q.day;
  assign evt_alarm_tod  = evt_q.alarm_tod;
  assign evt_alarm_full = evt_q.alarm_full;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_en,
  input logic        div_en,
  input logic        time_ld,
  input logic [31:0] time_ld_val,
  input logic        alarm_ld,
  input logic [31:0] alarm_ld_val,
  input logic [31:0] time_word,
  input logic        evt_sec,
  input logic        evt_min,
  input logic        evt_hour,
  input logic        evt_day,
  input logic        evt_alarm_tod,
  input logic        evt_alarm_full
);
  a_r7_min_needs_sec: assert property (@(posedge clk) disable iff (!rst_n)
    evt_min |-> evt_sec);

  a_r7_rollover_chain: assert property (@(posedge clk) disable iff (!rst_n)
    evt_day |-> (evt_hour && evt_min));

  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sec && !evt_min) |-> (time_word[5:0] == $past(time_word[5:0]) + 6'd1));

  a_r2_min_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    evt_min |-> (time_word[5:0] == 6'd0));

  a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    time_ld |=> ((time_word == $past(time_ld_val)) && !evt_sec));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en && !time_ld) |=> ($stable(time_word) && !evt_sec));

  a_r8_alarm_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm_tod |-> evt_sec);

  a_r9_full_implies_tod: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm_full |-> evt_alarm_tod);

  // R10: an alarm load alone raises no event
  a_r10_alarm_ld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_ld && !ref_en) |=> !evt_sec);
endmodule

bind tod_counter tod_counter_chk i_chk (.*);

// File: tb/test_tod_counter.sv
module test_tod_counter;
  localparam int DIV = 32768;

  logic        clk;
  logic        rst_n;
  logic        ref_en, div_en, time_ld, alarm_ld;
  logic [31:0] time_ld_val, alarm_ld_val, time_word;
  logic        evt_sec, evt_min, evt_hour, evt_day, evt_alarm_tod, evt_alarm_full;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] qt[$];
  logic [5:0]  qe[$];
  string       qs[$];

  logic [31:0] m_time, m_alarm;
  int          m_pc;

  tod_counter #(.DIV_COUNT(DIV)) i_tod_counter (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .div_en(div_en),
    .time_ld(time_ld), .time_ld_val(time_ld_val),
    .alarm_ld(alarm_ld), .alarm_ld_val(alarm_ld_val),
    .time_word(time_word), .evt_sec(evt_sec), .evt_min(evt_min),
    .evt_hour(evt_hour), .evt_day(evt_day),
    .evt_alarm_tod(evt_alarm_tod), .evt_alarm_full(evt_alarm_full)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // R1: day 31:17, hour 16:12, minute 11:6, second 5:0
  function automatic logic [31:0] mk(int d, int h, int m, int s);
    return {d[14:0], h[4:0], m[5:0], s[5:0]};
  endfunction

  function automatic logic [5:0] dut_ev();
    return {evt_alarm_full, evt_alarm_tod, evt_day, evt_hour, evt_min, evt_sec};
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input bit r, input bit dv, input bit ld, input logic [31:0] lv,
                      input bit ald, input logic [31:0] av, input string tag);
    bit tick;
    logic [5:0] ev;
    int s, mi, h, d;
    bit ws, wm, wh;
    @(negedge clk);
    ref_en = r; div_en = dv; time_ld = ld; time_ld_val = lv;
    alarm_ld = ald; alarm_ld_val = av;
    tick = r && (!dv || m_pc == DIV - 1);
    ev = '0;
    if (ld) begin
      m_time = lv;
    end else if (tick) begin
      s = int'(m_time[5:0]); mi = int'(m_time[11:6]);
      h = int'(m_time[16:12]); d = int'(m_time[31:17]);
      ws = (s >= 59);  s  = ws ? 0 : s + 1;
      wm = ws && (mi >= 59); mi = wm ? 0 : (ws ? mi + 1 : mi);
      wh = wm && (h >= 23);  h  = wh ? 0 : (wm ? h + 1 : h);
      if (wh) d = (d + 1) % 32768;
      m_time = mk(d, h, mi, s);
      ev[0] = 1'b1; ev[1] = ws; ev[2] = wm; ev[3] = wh;
      ev[4] = (m_time[16:0] == m_alarm[16:0]);
      ev[5] = ev[4] && (m_time[31:17] == m_alarm[31:17]);
    end
    if (ld || !dv) m_pc = 0;
    else if (r) m_pc = tick ? 0 : m_pc + 1;
    if (ald) m_alarm = av;
    qt.push_back(m_time); qe.push_back(ev); qs.push_back(tag);
  endtask

  task automatic tick_n(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, '0, 0, '0, tag);
  endtask

  task automatic load(input logic [31:0] v, input string tag);
    step(0, 0, 1, v, 0, '0, tag);
  endtask

  // Monitor: compares one queued item just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qt.size() > 0) begin
        logic [31:0] et;
        logic [5:0]  ee;
        string       tg;
        et = qt.pop_front(); ee = qe.pop_front(); tg = qs.pop_front();
        n_checks++;
        if (time_word !== et || dut_ev() !== ee) begin
          n_fail++;
          $display("FAIL %s: time=%h ev=%b expected time=%h ev=%b",
                   tg, time_word, dut_ev(), et, ee);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): state=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_en = 0; div_en = 0; time_ld = 0; alarm_ld = 0;
    time_ld_val = '0; alarm_ld_val = '0;
    m_time = '0; m_alarm = '0; m_pc = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    n_checks++;
    if (time_word !== 32'h0 || dut_ev() !== 6'h0) begin
      n_fail++;
      $display("FAIL R11: time=%h ev=%b expected time=0 ev=000000", time_word, dut_ev());
    end

    // R4 / R7: direct ticks, then idle cycles hold
    tick_n(3, "R4 tick per ref pulse");
    step(0, 0, 0, '0, 0, '0, "R4 idle hold");
    step(0, 0, 0, '0, 0, '0, "R4 idle hold");

    // R11: alarm resets to zero, so reaching 00:00:00 on day 1 hits the tod alarm only
    load(mk(0, 23, 59, 59), "R5 load");
    tick_n(1, "R11 alarm zero after reset / R2 hour wrap / R7 day pulse");

    // R2: seconds into minutes
    load(mk(2, 4, 0, 58), "R5 load");
    tick_n(2, "R2 seconds wrap carries R7 min pulse");
    load(mk(2, 4, 59, 59), "R5 load");
    tick_n(1, "R2 minutes wrap carries R7 hour pulse");
    load(mk(5, 23, 59, 58), "R5 load");
    tick_n(2, "R2 hours wrap into day R1 fields");

    // R6: day count wraps
    load(mk(32767, 23, 59, 59), "R5 load");
    tick_n(2, "R6 day wrap to zero");

    // R8 / R9 / R10
    step(0, 0, 0, '0, 1, mk(3, 10, 20, 30), "R10 alarm load quiet");
    load(mk(1, 10, 20, 29), "R5 load");
    tick_n(2, "R8 tod alarm other day");
    load(mk(3, 10, 20, 29), "R5 load");
    tick_n(1, "R9 full alarm same day");
    load(mk(3, 10, 20, 29), "R5 load");
    step(1, 0, 0, '0, 1, mk(7, 1, 1, 1), "R10 same-cycle compare uses old alarm");
    load(mk(7, 1, 1, 0), "R5 load");
    tick_n(1, "R10 new alarm in effect R9");

    // R5: load wins over a tick in the same cycle
    step(1, 0, 1, mk(9, 12, 34, 56), 0, '0, "R5 load beats tick");
    tick_n(1, "R5 after load");

    // R3: prescaled second
    load(mk(0, 0, 0, 10), "R5 load");
    for (int i = 0; i < DIV - 1; i++) step(1, 1, 0, '0, 0, '0, "R3 no tick before 32768 pulses");
    step(1, 1, 0, '0, 0, '0, "R3 tick on pulse 32768");
    // R5: load mid-phase restarts the prescaler
    for (int i = 0; i < 100; i++) step(1, 1, 0, '0, 0, '0, "R3 partial phase");
    step(0, 1, 1, mk(0, 0, 0, 20), 0, '0, "R5 load restarts phase");
    for (int i = 0; i < DIV - 1; i++) step(1, 1, 0, '0, 0, '0, "R5 full second after load");
    step(1, 1, 0, '0, 0, '0, "R5 tick a full second after load");
    step(0, 0, 0, '0, 0, '0, "R4 idle hold");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule